// File: doc/BRIEF.md
# Two-Level Interrupt Status Controller

This block gathers single-cycle event pulses into two 32-bit status words and drives one active-low interrupt request. Every status bit is latched regardless of masking; a matching bit in one of two mask words decides whether it pulls the request line low. The host reads the status words through a small register port and clears flags by writing ones back.

A subset of status bits are summaries: each stands for per-phase detail kept in a second-level register. Word 1 carries a current-peak summary (bit 23) and a voltage-peak summary (bit 24), each backed by a three-bit phase register. Word 0 carries nine sign-change summaries (active-power reversal per phase on bits 6..8, reactive-power reversal per phase on bits 10..12, summed-power sign changes on bits 9, 13 and 18), backed by one nine-bit sign register. A summary bit only accepts a write-back clear after its detail register has been read since the bit's latest event, so the host cannot drop phase information it never saw.

Top module: `irqstat_top`

## Requirements
- R1: After reset every readable register (addresses 0..7) reads zero and `irqN` is high.
- R2: An event pulse on bit b of word w sets status bit b of word w on the next clock edge whatever the masks hold; `irqN` goes low if and only if some status bit is set whose mask bit (mask0 at address 2 for word 0, mask1 at address 3 for word 1) is also set.
- R3: Writing a status word (address 0 or 1) clears each non-summary bit written as 1; bits written as 0 keep their value; `irqN` returns high once no enabled flag remains.
- R4: When an event and a write-one-to-clear hit the same bit in the same cycle, the bit ends up set.
- R5: A clear of a summary bit (word 1 bits 23 and 24; word 0 bits 6..13 and 18) is ignored unless its detail register (address 4 current-peak, 5 voltage-peak, 6 sign) was read with a read strobe after that bit's latest event; after such a read the clear takes effect.
- R6: A new event on a summary bit cancels any earlier detail read for that bit, so a clear is again ignored until the detail is read anew.
- R7: The current-peak (voltage-peak) detail register ORs in the three phase bits (bit 0 phase A, bit 1 B, bit 2 C) given with each bit-23 (bit-24) event of word 1 and returns to zero when that summary bit is cleared.
- R8: The sign detail register sets bit i when its summary bit fires: bits 0..2 for word-0 bits 6..8, bits 3..5 for bits 10..12, bit 6 for bit 9, bit 7 for bit 13, bit 8 for bit 18; each detail bit clears together with its own summary bit only.
- R9: Mask words are plain read/write registers; writes to addresses 4..7 change nothing, and address 7 always reads zero.
- R10: An event that lands after the host snapshots a status word survives the write-back of that snapshot and keeps `irqN` low when enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt0 | input | 32 | Event pulses for status word 0 |
| evt1 | input | 32 | Event pulses for status word 1 |
| ipkPhase | input | 3 | Phases involved in a current-peak event |
| vpkPhase | input | 3 | Phases involved in a voltage-peak event |
| hostAddr | input | 3 | Register address |
| hostWr | input | 1 | Write strobe |
| hostRd | input | 1 | Read strobe (marks detail registers as read) |
| hostWdata | input | 32 | Write data |
| hostRdata | output | 32 | Read data for `hostAddr`, combinational |
| irqN | output | 1 | Active-low interrupt request |

## Verification
The colliding pair is an event pulse and a host write-one-to-clear on the same bit in one cycle; the bench drives both on the same edge and expects the bit still set, then services it normally. A second collision, a fresh summary event after the detail was read but before the clear, is provoked on the current-peak bit and judged by the clear being refused until the detail is read again with both phases present. The main sweep walks every bit of both words with its mask on and off, computing from the bit position whether it is a summary bit and what the detail register must hold.

// File: rtl/irqstat_pkg.sv
package irqstat_pkg;

  typedef enum logic [2:0] {
    ADR_STAT0 = 3'd0,
    ADR_STAT1 = 3'd1,
    ADR_MASK0 = 3'd2,
    ADR_MASK1 = 3'd3,
    ADR_IPK   = 3'd4,
    ADR_VPK   = 3'd5,
    ADR_SIGN  = 3'd6,
    ADR_NONE  = 3'd7
  } regAddr_e;

  typedef struct packed {
    logic clr0;
    logic clr1;
    logic wrMask0;
    logic wrMask1;
    logic rdIpk;
    logic rdVpk;
    logic rdSign;
  } hostStrobe_t;

endpackage

// File: rtl/irqstat_ctrl.sv
module irqstat_ctrl
  import irqstat_pkg::*;
(
  input  logic        hostWr,
  input  logic        hostRd,
  input  logic [2:0]  hostAddr,
  output hostStrobe_t stb,
  output regAddr_e    rdSel
);

  always_comb begin
    rdSel = regAddr_e'(hostAddr);
    stb   = '0;
    if (hostWr) begin
      case (rdSel)
        ADR_STAT0: stb.clr0    = 1'b1;
        ADR_STAT1: stb.clr1    = 1'b1;
        ADR_MASK0: stb.wrMask0 = 1'b1;
        ADR_MASK1: stb.wrMask1 = 1'b1;
        default:   ;
      endcase
    end
    if (hostRd) begin
      case (rdSel)
        ADR_IPK:  stb.rdIpk  = 1'b1;
        ADR_VPK:  stb.rdVpk  = 1'b1;
        ADR_SIGN: stb.rdSign = 1'b1;
        default:  ;
      endcase
    end
  end

endmodule

// File: rtl/irqstat_word.sv
module irqstat_word #(
  parameter int                 DATA_W = 32,
  parameter logic [DATA_W-1:0]  LINK   = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] evt,
  input  logic              clrStb,
  input  logic [DATA_W-1:0] clrData,
  input  logic [DATA_W-1:0] rdSet,
  output logic [DATA_W-1:0] status,
  output logic [DATA_W-1:0] clrEff
);

  logic [DATA_W-1:0] rdFlag;

  // a linked bit may only be cleared once its detail has been read
  always_comb begin
    clrEff = clrStb ? (clrData & (~LINK | rdFlag)) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      rdFlag <= '0;
    end else begin
      status <= (status & ~clrEff) | evt;
      rdFlag <= ((rdFlag | rdSet) & ~evt) & LINK;
    end
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (evt != '0) |=> ((status & $past(evt)) == $past(evt))); // R4

  AST_LINK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (clrStb && ((clrData & LINK & ~rdFlag & status) != '0))
    |=> ((status & $past(clrData & LINK & ~rdFlag & status))
         == $past(clrData & LINK & ~rdFlag & status))); // R5

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (rst)
    clrStb |=> ((status & ~$past(status) & ~$past(evt)) == '0)); // R3

endmodule

// File: rtl/irqstat_datapath.sv
module irqstat_datapath
  import irqstat_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NPH       = 3,
  parameter int IPK_BIT   = 23,
  parameter int VPK_BIT   = 24,
  parameter int ACT_LSB   = 6,
  parameter int REACT_LSB = 10,
  parameter int SUM_ACT   = 9,
  parameter int SUM_REACT = 13,
  parameter int SUM_APP   = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] evt0,
  input  logic [DATA_W-1:0] evt1,
  input  logic [NPH-1:0]    ipkPhase,
  input  logic [NPH-1:0]    vpkPhase,
  input  hostStrobe_t       stb,
  input  regAddr_e          rdSel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irqN
);

  localparam int SIGN_W = 2 * NPH + 3;

  function automatic int signPos(input int i);
    if (i < NPH)          return ACT_LSB + i;
    else if (i < 2 * NPH) return REACT_LSB + i - NPH;
    else if (i == 2 * NPH) return SUM_ACT;
    else if (i == 2 * NPH + 1) return SUM_REACT;
    else return SUM_APP;
  endfunction

  function automatic logic [DATA_W-1:0] link0Mask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < SIGN_W; i++) m[signPos(i)] = 1'b1;
    return m;
  endfunction

  localparam logic [DATA_W-1:0] LINK0 = link0Mask();
  localparam logic [DATA_W-1:0] BIT_IPK = DATA_W'(1) << IPK_BIT;
  localparam logic [DATA_W-1:0] BIT_VPK = DATA_W'(1) << VPK_BIT;
  localparam logic [DATA_W-1:0] LINK1 = BIT_IPK | BIT_VPK;

  logic [DATA_W-1:0] status0, status1, clrEff0, clrEff1;
  logic [DATA_W-1:0] mask0, mask1, rdSet0, rdSet1;
  logic [NPH-1:0]    ipkDetail, vpkDetail;
  logic [SIGN_W-1:0] signDetail, signNew, signClr, signSum;

  assign rdSet0 = {DATA_W{stb.rdSign}} & LINK0;
  assign rdSet1 = ({DATA_W{stb.rdIpk}} & BIT_IPK) | ({DATA_W{stb.rdVpk}} & BIT_VPK);

  irqstat_word #(.DATA_W(DATA_W), .LINK(LINK0)) u_word0 (
    .clk(clk), .rst(rst), .evt(evt0), .clrStb(stb.clr0), .clrData(wdata),
    .rdSet(rdSet0), .status(status0), .clrEff(clrEff0)
  );

  irqstat_word #(.DATA_W(DATA_W), .LINK(LINK1)) u_word1 (
    .clk(clk), .rst(rst), .evt(evt1), .clrStb(stb.clr1), .clrData(wdata),
    .rdSet(rdSet1), .status(status1), .clrEff(clrEff1)
  );

  // masks
  always_ff @(posedge clk) begin
    if (rst) begin
      mask0 <= '0;
      mask1 <= '0;
    end else begin
      if (stb.wrMask0) mask0 <= wdata;
      if (stb.wrMask1) mask1 <= wdata;
    end
  end

  // peak detail registers
  always_ff @(posedge clk) begin
    if (rst) begin
      ipkDetail <= '0;
      vpkDetail <= '0;
    end else begin
      ipkDetail <= (ipkDetail & {NPH{~clrEff1[IPK_BIT]}})
                 | (evt1[IPK_BIT] ? ipkPhase : '0);
      vpkDetail <= (vpkDetail & {NPH{~clrEff1[VPK_BIT]}})
                 | (evt1[VPK_BIT] ? vpkPhase : '0);
    end
  end

  // sign detail: one bit per linked summary bit
  for (genvar i = 0; i < SIGN_W; i++) begin : g_sign
    localparam int P = signPos(i);
    assign signNew[i] = evt0[P];
    assign signClr[i] = clrEff0[P];
    assign signSum[i] = status0[P];
  end

  always_ff @(posedge clk) begin
    if (rst) signDetail <= '0;
    else     signDetail <= (signDetail & ~signClr) | signNew;
  end

  always_comb begin
    case (rdSel)
      ADR_STAT0: rdata = status0;
      ADR_STAT1: rdata = status1;
      ADR_MASK0: rdata = mask0;
      ADR_MASK1: rdata = mask1;
      ADR_IPK:   rdata = DATA_W'(ipkDetail);
      ADR_VPK:   rdata = DATA_W'(vpkDetail);
      ADR_SIGN:  rdata = DATA_W'(signDetail);
      default:   rdata = '0;
    endcase
  end

  assign irqN = ~|((status0 & mask0) | (status1 & mask1));

  AST_IRQ_ON_EVENT: assert property (@(posedge clk) disable iff (rst)
    ((((evt0 & mask0) | (evt1 & mask1)) != '0) && !stb.wrMask0 && !stb.wrMask1)
    |=> !irqN); // R2

  AST_IPK_DETAIL: assert property (@(posedge clk) disable iff (rst)
    (ipkDetail != '0) |-> status1[IPK_BIT]); // R7

  AST_VPK_DETAIL: assert property (@(posedge clk) disable iff (rst)
    (vpkDetail != '0) |-> status1[VPK_BIT]); // R7

  AST_SIGN_DETAIL: assert property (@(posedge clk) disable iff (rst)
    ((signDetail & ~signSum) == '0)); // R8

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!stb.wrMask0 && !stb.wrMask1) |=> ($stable(mask0) && $stable(mask1))); // R9

endmodule

// File: rtl/irqstat_top.sv
module irqstat_top
  import irqstat_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NPH    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] evt0,
  input  logic [DATA_W-1:0] evt1,
  input  logic [NPH-1:0]    ipkPhase,
  input  logic [NPH-1:0]    vpkPhase,
  input  logic [2:0]        hostAddr,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic              irqN
);

  hostStrobe_t stb;
  regAddr_e    rdSel;

  irqstat_ctrl u_ctrl (
    .hostWr(hostWr), .hostRd(hostRd), .hostAddr(hostAddr),
    .stb(stb), .rdSel(rdSel)
  );

  irqstat_datapath #(.DATA_W(DATA_W), .NPH(NPH)) u_dp (
    .clk(clk), .rst(rst), .evt0(evt0), .evt1(evt1),
    .ipkPhase(ipkPhase), .vpkPhase(vpkPhase),
    .stb(stb), .rdSel(rdSel), .wdata(hostWdata),
    .rdata(hostRdata), .irqN(irqN)
  );

endmodule

// File: tb/irqstat_top_bench.sv
`timescale 1ns/1ps
module irqstat_top_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] evt0 = '0, evt1 = '0;
  logic [2:0]  ipkPhase = '0, vpkPhase = '0;
  logic [2:0]  hostAddr = '0;
  logic        hostWr = 1'b0, hostRd = 1'b0;
  logic [31:0] hostWdata = '0;
  logic [31:0] hostRdata;
  logic        irqN;
  int          checks = 0;
  int          fails  = 0;

  always #4 clk = ~clk;

  irqstat_top u_irqstat_top (
    .clk(clk), .rst(rst), .evt0(evt0), .evt1(evt1),
    .ipkPhase(ipkPhase), .vpkPhase(vpkPhase),
    .hostAddr(hostAddr), .hostWr(hostWr), .hostRd(hostRd),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .irqN(irqN)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    hostAddr = a; hostWdata = d; hostWr = 1'b1;
    cyc();
    hostWr = 1'b0; hostWdata = '0;
  endtask

  task automatic rdHost(input logic [2:0] a, output logic [31:0] d);
    hostAddr = a; hostRd = 1'b1;
    #1 d = hostRdata;
    cyc();
    hostRd = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [31:0] d);
    hostAddr = a;
    #1 d = hostRdata;
  endtask

  task automatic pulse(input int w, input logic [31:0] v);
    if (w == 1) evt1 = v; else evt0 = v;
    cyc();
    evt0 = '0; evt1 = '0;
  endtask

  function automatic bit linked(input int w, input int b);
    if (w == 1) return (b == 23) || (b == 24);
    return (b >= 6 && b <= 13) || (b == 18);
  endfunction

  function automatic int signIdx(input int b);
    if (b >= 6 && b <= 8)   return b - 6;
    if (b >= 10 && b <= 12) return b - 7;
    if (b == 9)  return 6;
    if (b == 13) return 7;
    return 8;
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    logic [31:0] snap;
    repeat (3) cyc();
    rst = 1'b0;
    cyc();

    // R1: reset state
    for (int a = 0; a < 8; a++) begin
      peek(3'(a), d);
      check("R1 reset read", d, 32'h0);
    end
    check("R1 reset irqN", {31'b0, irqN}, 32'h1);

    // R2 R3 R5 R7 R8: sweep every bit of both words, mask on and off
    ipkPhase = 3'b101; vpkPhase = 3'b101;
    for (int w = 0; w < 2; w++) begin
      for (int b = 0; b < 32; b++) begin
        for (int m = 0; m < 2; m++) begin
          logic [31:0] bv;
          logic [2:0]  sa, ma, da;
          logic [31:0] dexp;
          bv = 32'h1 << b;
          sa = (w == 1) ? 3'd1 : 3'd0;
          ma = (w == 1) ? 3'd3 : 3'd2;
          da = (w == 0) ? 3'd6 : ((b == 23) ? 3'd4 : 3'd5);
          dexp = (w == 0) ? (32'h1 << signIdx(b)) : 32'h5;
          wr(ma, (m == 1) ? bv : 32'h0);
          pulse(w, bv);
          peek(sa, d);           check("R2 status set", d, bv);
          peek(sa ^ 3'd1, d);    check("R2 other word clear", d, 32'h0);
          check("R2 irqN vs mask", {31'b0, irqN}, (m == 1) ? 32'h0 : 32'h1);
          wr(sa, 32'h0);
          peek(sa, d);           check("R3 zero write no effect", d, bv);
          wr(sa, bv);
          peek(sa, d);
          if (linked(w, b)) begin
            check("R5 clear refused before detail read", d, bv);
            check("R5 irqN held", {31'b0, irqN}, (m == 1) ? 32'h0 : 32'h1);
            rdHost(da, d);
            check((w == 0) ? "R8 sign detail" : "R7 peak detail", d, dexp);
            wr(sa, bv);
            peek(sa, d);         check("R5 clear after detail read", d, 32'h0);
            peek(da, d);
            check((w == 0) ? "R8 sign detail cleared" : "R7 peak detail cleared", d, 32'h0);
          end else begin
            check("R3 clear", d, 32'h0);
          end
          check("R3 irqN released", {31'b0, irqN}, 32'h1);
          wr(ma, 32'h0);
        end
      end
    end

    // R4: set and clear in the same cycle
    pulse(0, 32'h8);
    hostAddr = 3'd0; hostWdata = 32'h8; hostWr = 1'b1; evt0 = 32'h8;
    cyc();
    hostWr = 1'b0; evt0 = '0; hostWdata = '0;
    peek(3'd0, d); check("R4 set wins", d, 32'h8);
    wr(3'd0, 32'h8);
    peek(3'd0, d); check("R4 later clear", d, 32'h0);

    // R6 R7 R9: new event after detail read cancels the read
    ipkPhase = 3'b001; pulse(1, 32'h1 << 23);
    rdHost(3'd4, d); check("R7 phase A captured", d, 32'h1);
    ipkPhase = 3'b010; pulse(1, 32'h1 << 23);
    wr(3'd1, 32'h1 << 23);
    peek(3'd1, d); check("R6 clear refused after new event", d, 32'h1 << 23);
    wr(3'd4, 32'hFFFF_FFFF);
    rdHost(3'd4, d); check("R7 phases accumulate, R9 detail write ignored", d, 32'h3);
    wr(3'd1, 32'h1 << 23);
    peek(3'd1, d); check("R6 clear after re-read", d, 32'h0);
    peek(3'd4, d); check("R7 detail cleared", d, 32'h0);

    // R8: per-bit clear of sign detail
    pulse(0, (32'h1 << 6) | (32'h1 << 9));
    rdHost(3'd6, d); check("R8 sign detail two bits", d, 32'h41);
    wr(3'd0, 32'h1 << 6);
    peek(3'd0, d); check("R8 only bit 6 cleared", d, 32'h1 << 9);
    peek(3'd6, d); check("R8 sign detail partial", d, 32'h40);
    wr(3'd0, 32'h1 << 9);
    peek(3'd0, d); check("R8 bit 9 cleared", d, 32'h0);
    peek(3'd6, d); check("R8 sign detail empty", d, 32'h0);

    // R9: masks read/write, address 7 reads zero
    wr(3'd2, 32'hA5A5_0F0F);
    peek(3'd2, d); check("R9 mask0 readback", d, 32'hA5A5_0F0F);
    wr(3'd3, 32'h1234_5678);
    peek(3'd3, d); check("R9 mask1 readback", d, 32'h1234_5678);
    wr(3'd7, 32'hFFFF_FFFF);
    peek(3'd7, d); check("R9 address 7 zero", d, 32'h0);
    peek(3'd2, d); check("R9 mask0 untouched", d, 32'hA5A5_0F0F);

    // R10: event during service survives write-back of snapshot
    wr(3'd2, 32'h3); wr(3'd3, 32'h0);
    pulse(0, 32'h1);
    peek(3'd0, snap); check("R10 snapshot", snap, 32'h1);
    pulse(0, 32'h2);
    wr(3'd0, snap);
    peek(3'd0, d); check("R10 late event kept", d, 32'h2);
    check("R10 irqN still low", {31'b0, irqN}, 32'h0);
    wr(3'd0, 32'h2);
    check("R10 irqN released", {31'b0, irqN}, 32'h1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule